// File: doc/BRIEF.md
# Circular and Bit-Reversed Stream Address Generator

This unit produces memory addresses for a streaming buffer, as a DSP datapath needs them. It holds a buffer window given by a lower and an upper bound register, a running pointer, and a step configuration. The step configuration sets the element size in bytes and the transform order used by the bit-reversed walk. Each advance strobe makes the unit report one address and then move to the next position. Three walks are available. The first walks upward and folds back to the lower bound after passing the upper bound. The second walks downward and folds back to the upper bound after dropping below the lower bound. The third visits a power-of-two FFT buffer in bit-reversed index order.

Software-side logic loads the bound, pointer and step registers through dedicated write strobes. The consuming datapath raises the advance strobe once per access and picks the reported address up one cycle later, together with a valid flag. The reported address is always the position before the move (post-modify). The circular walks move the pointer, while the bit-reversed walk moves a separate index counter. The two walks can therefore be interleaved without disturbing each other.

Top module: `agu_stream_addr`

## Requirements
- R1: When `adv_i` is high and no write strobe is high, `addr_vld_o` is high in the next cycle with the reported address on `addr_o`. In any cycle after one without an accepted advance, `addr_vld_o` is low.
- R2: Mode code 2'b00 (upward) reports the pointer and then adds the element size to it. If the sum, taken without truncation to the address width, is greater than the upper bound, the pointer becomes the lower bound instead.
- R3: Mode code 2'b01 (downward) reports the pointer and then subtracts the element size. If the difference, taken without borrow wrap, is below the lower bound, the pointer becomes the upper bound instead.
- R4: Mode codes 2'b10 and 2'b11 (bit-reversed) report the lower bound plus the element size times the index reversed over k bits. The index then increments modulo 2^k. The pointer is untouched, and the circular modes leave the index untouched.
- R5: The order k is the value on `fft_order_i` at the step write, clamped so that 0 gives 1 and anything above 10 gives 10.
- R6: `step_sel_i` codes 0, 1, 2 and 3 select element sizes of 1, 2, 4 and 8 bytes, latched by `wr_step_i`.
- R7: A register write is visible from the next cycle. When a write strobe and `adv_i` are high in the same cycle, the advance is dropped: no valid address follows, and neither pointer nor index moves.
- R8: Writing the lower bound, the pointer or the step configuration resets the bit-reverse index to 0. Writing the upper bound does not.
- R9: After reset, both bounds and the pointer are 0, the element size is 1 byte, k is 1, the index is 0 and `addr_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start_i | input | 1 | Load strobe for the lower bound |
| start_i | input | ADDR_W | Lower bound value |
| wr_end_i | input | 1 | Load strobe for the upper bound |
| end_i | input | ADDR_W | Upper bound value (last valid element address) |
| wr_ptr_i | input | 1 | Load strobe for the pointer |
| ptr_i | input | ADDR_W | Pointer value |
| wr_step_i | input | 1 | Load strobe for size and order |
| step_sel_i | input | 2 | Element size code |
| fft_order_i | input | ORD_W | Bit-reverse order before clamping |
| mode_i | input | 2 | Walk select, sampled with the advance |
| adv_i | input | 1 | Advance strobe |
| addr_o | output | ADDR_W | Reported address |
| addr_vld_o | output | 1 | Address valid, one cycle after an accepted advance |

## Verification
The window assertions assume that the pointer sits inside the window and on an element boundary whenever a circular advance is issued. They also assume that a bit-reversed buffer fits below the top of the address space. The stimulus meets both conditions: it loads bounds and pointer before any circular advance, and it chooses pointer values that are whole element steps from the lower bound. It places every bit-reversed window low in the address space. The wrap corners at the address-space limits are still driven: a sum that overflows the address width, and a difference that borrows below zero.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        STEP_UP      = 2'b00,
        STEP_DOWN    = 2'b01,
        STEP_REV     = 2'b10,
        STEP_REV_ALT = 2'b11
    } step_mode_e;

    function automatic logic mode_is_rev(step_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/agu_ring_step.sv
module agu_ring_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [ADDR_W-1:0] lo_i,
    input  logic [ADDR_W-1:0] hi_i,
    input  logic [ADDR_W-1:0] size_i,
    input  logic              down_i,
    output logic [ADDR_W-1:0] nxt_o
);
    // One extra bit keeps carry and borrow visible to the fold decision.
    logic [ADDR_W:0] sum_w;
    logic [ADDR_W:0] floor_w;

    always_comb begin
        sum_w   = {1'b0, ptr_i} + {1'b0, size_i};
        floor_w = {1'b0, lo_i} + {1'b0, size_i};
        if (down_i) begin
            if ({1'b0, ptr_i} < floor_w) nxt_o = hi_i;
            else                         nxt_o = ptr_i - size_i;
        end else begin
            if (sum_w > {1'b0, hi_i})    nxt_o = lo_i;
            else                         nxt_o = sum_w[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
    parameter int ADDR_W    = 16,
    parameter int MAX_ORDER = 10,
    localparam int ORD_W    = $clog2(MAX_ORDER + 1),
    localparam int IDX_W    = MAX_ORDER
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [ORD_W-1:0]  order_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        sz_sel_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [IDX_W-1:0]  idx_nxt_o
);
    logic [IDX_W-1:0]  rev_full;
    logic [IDX_W-1:0]  rev_k;
    logic [ORD_W-1:0]  shamt;
    logic [IDX_W-1:0]  mask;
    logic [ADDR_W-1:0] offset;

    // Mirror all IDX_W bits; the right shift then leaves the k-bit reversal.
    for (genvar g = 0; g < IDX_W; g++) begin : g_mirror
        assign rev_full[g] = idx_i[IDX_W-1-g];
    end

    always_comb begin
        shamt     = ORD_W'(IDX_W) - order_i;
        rev_k     = rev_full >> shamt;
        offset    = ADDR_W'(rev_k) << sz_sel_i;
        addr_o    = base_i + offset;
        mask      = (IDX_W'(1) << order_i) - IDX_W'(1);
        idx_nxt_o = (idx_i + IDX_W'(1)) & mask;
    end
endmodule

// File: rtl/agu_stream_addr.sv
module agu_stream_addr
    import agu_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MAX_ORDER = 10,
    localparam int ORD_W    = $clog2(MAX_ORDER + 1),
    localparam int IDX_W    = MAX_ORDER
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic              wr_end_i,
    input  logic [ADDR_W-1:0] end_i,
    input  logic              wr_ptr_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic              wr_step_i,
    input  logic [1:0]        step_sel_i,
    input  logic [ORD_W-1:0]  fft_order_i,
    input  logic [1:0]        mode_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_vld_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [ADDR_W-1:0] ptr;
        logic [1:0]        sz_sel;
        logic [ORD_W-1:0]  order;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic              vld;
    } agu_state_t;

    agu_state_t s_d, s_q;

    step_mode_e        mode;
    logic [ADDR_W-1:0] size;
    logic [ADDR_W-1:0] ring_nxt;
    logic [ADDR_W-1:0] rev_addr;
    logic [IDX_W-1:0]  rev_idx_nxt;
    logic [ORD_W-1:0]  order_clamped;
    logic              any_wr;

    assign mode = step_mode_e'(mode_i);
    assign size = ADDR_W'(1) << s_q.sz_sel;

    agu_ring_step #(.ADDR_W(ADDR_W)) u_ring (
        .ptr_i  (s_q.ptr),
        .lo_i   (s_q.lo),
        .hi_i   (s_q.hi),
        .size_i (size),
        .down_i (mode == STEP_DOWN),
        .nxt_o  (ring_nxt)
    );

    agu_bitrev #(.ADDR_W(ADDR_W), .MAX_ORDER(MAX_ORDER)) u_rev (
        .idx_i     (s_q.idx),
        .order_i   (s_q.order),
        .base_i    (s_q.lo),
        .sz_sel_i  (s_q.sz_sel),
        .addr_o    (rev_addr),
        .idx_nxt_o (rev_idx_nxt)
    );

    always_comb begin
        if (fft_order_i == '0)                        order_clamped = ORD_W'(1);
        else if (fft_order_i > ORD_W'(MAX_ORDER))     order_clamped = ORD_W'(MAX_ORDER);
        else                                          order_clamped = fft_order_i;
    end

    assign any_wr = wr_start_i | wr_end_i | wr_ptr_i | wr_step_i;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (any_wr) begin
            if (wr_start_i) s_d.lo  = start_i;
            if (wr_end_i)   s_d.hi  = end_i;
            if (wr_ptr_i)   s_d.ptr = ptr_i;
            if (wr_step_i) begin
                s_d.sz_sel = step_sel_i;
                s_d.order  = order_clamped;
            end
            if (wr_start_i | wr_ptr_i | wr_step_i) s_d.idx = '0;
        end else if (adv_i) begin
            s_d.vld = 1'b1;
            if (mode_is_rev(mode)) begin
                s_d.addr = rev_addr;
                s_d.idx  = rev_idx_nxt;
            end else begin
                s_d.addr = s_q.ptr;
                s_d.ptr  = ring_nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.order  <= ORD_W'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign addr_o     = s_q.addr;
    assign addr_vld_o = s_q.vld;
endmodule

// File: rtl/agu_stream_addr_chk.sv
module agu_stream_addr_chk #(
    parameter int ADDR_W    = 16,
    parameter int MAX_ORDER = 10,
    localparam int ORD_W    = $clog2(MAX_ORDER + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              any_wr,
    input logic              adv_i,
    input logic [1:0]        mode_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              addr_vld_o,
    input logic [ADDR_W-1:0] lo_q,
    input logic [ADDR_W-1:0] hi_q,
    input logic [1:0]        sz_sel_q,
    input logic [ORD_W-1:0]  order_q
);
    logic [31:0] off;
    logic [31:0] span;
    logic [31:0] align_m;

    assign off     = 32'(addr_o - lo_q);
    assign span    = 32'd1 << (int'(order_q) + int'(sz_sel_q));
    assign align_m = (32'd1 << sz_sel_q) - 32'd1;

    // R1: accepted advance yields a valid address
    a_r1_vld_after_adv: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && !any_wr |=> addr_vld_o);

    // R1: no advance, no valid address
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> !addr_vld_o);

    // R7: a write in the same cycle drops the advance
    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr |=> !addr_vld_o);

    // R2 and R3: circular walks stay inside the window
    a_r2_ring_inside: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld_o && !$past(mode_i[1]) |-> (addr_o >= lo_q) && (addr_o <= hi_q));

    // R4: bit-reversed addresses lie in the buffer, on element boundaries
    a_r4_rev_span: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld_o && $past(mode_i[1]) |-> (addr_o >= lo_q) && (off < span) && ((off & align_m) == 32'd0));

    // R5: stored order is always within the clamped range
    a_r5_order_range: assert property (@(posedge clk) disable iff (!rst_n)
        $past(any_wr) |-> (order_q >= ORD_W'(1)) && (order_q <= ORD_W'(MAX_ORDER)));
endmodule

bind agu_stream_addr agu_stream_addr_chk #(.ADDR_W(ADDR_W), .MAX_ORDER(MAX_ORDER)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_wr     (any_wr),
    .adv_i      (adv_i),
    .mode_i     (mode_i),
    .addr_o     (addr_o),
    .addr_vld_o (addr_vld_o),
    .lo_q       (s_q.lo),
    .hi_q       (s_q.hi),
    .sz_sel_q   (s_q.sz_sel),
    .order_q    (s_q.order)
);

// File: tb/tb_agu_stream_addr.sv
`timescale 1ns/1ps
module tb_agu_stream_addr;
    localparam int ADDR_W = 16;
    localparam int ORD_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_start_i = 0, wr_end_i = 0, wr_ptr_i = 0, wr_step_i = 0, adv_i = 0;
    logic [ADDR_W-1:0] start_i = '0, end_i = '0, ptr_i = '0;
    logic [1:0] step_sel_i = '0, mode_i = '0;
    logic [ORD_W-1:0] fft_order_i = '0;
    logic [ADDR_W-1:0] addr_o;
    logic addr_vld_o;

    always #2.5 clk = ~clk;

    agu_stream_addr dut (
        .clk(clk), .rst_n(rst_n),
        .wr_start_i(wr_start_i), .start_i(start_i),
        .wr_end_i(wr_end_i), .end_i(end_i),
        .wr_ptr_i(wr_ptr_i), .ptr_i(ptr_i),
        .wr_step_i(wr_step_i), .step_sel_i(step_sel_i), .fft_order_i(fft_order_i),
        .mode_i(mode_i), .adv_i(adv_i),
        .addr_o(addr_o), .addr_vld_o(addr_vld_o)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int    exp_addr[$];
    string exp_tag[$];

    // bench model of the programmed state
    int m_lo = 0, m_hi = 0, m_ptr = 0, m_sz = 1, m_k = 1, m_idx = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=0x%0h exp=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int rev_bits(int v, int k);
        int r = 0;
        for (int i = 0; i < k; i++)
            if (v[i]) r |= (1 << (k - 1 - i));
        return r;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && addr_vld_o) begin
            if (exp_addr.size() == 0) begin
                chk(0, "R1 unexpected valid", int'(addr_o), -1);
            end else begin
                int e;
                string t;
                e = exp_addr.pop_front();
                t = exp_tag.pop_front();
                chk(int'(addr_o) == e, t, int'(addr_o), e);
            end
        end
    end

    task automatic wr_lo(int v);
        wr_start_i = 1; start_i = ADDR_W'(v); m_lo = v; m_idx = 0;
        @(negedge clk); wr_start_i = 0;
    endtask
    task automatic wr_hi(int v);
        wr_end_i = 1; end_i = ADDR_W'(v); m_hi = v;
        @(negedge clk); wr_end_i = 0;
    endtask
    task automatic wr_pt(int v);
        wr_ptr_i = 1; ptr_i = ADDR_W'(v); m_ptr = v; m_idx = 0;
        @(negedge clk); wr_ptr_i = 0;
    endtask
    task automatic wr_cfg(int sel, int ord);
        wr_step_i = 1; step_sel_i = 2'(sel); fft_order_i = ORD_W'(ord);
        m_sz = 1 << sel;
        m_k = (ord == 0) ? 1 : (ord > 10) ? 10 : ord;
        m_idx = 0;
        @(negedge clk); wr_step_i = 0;
    endtask

    task automatic adv(int mode, string tag);
        int e;
        if (mode >= 2) begin
            e = (m_lo + rev_bits(m_idx, m_k) * m_sz) & 16'hFFFF;
            m_idx = (m_idx + 1) % (1 << m_k);
        end else if (mode == 0) begin
            e = m_ptr;
            m_ptr = (m_ptr + m_sz > m_hi) ? m_lo : m_ptr + m_sz;
        end else begin
            e = m_ptr;
            m_ptr = (m_ptr - m_sz < m_lo) ? m_hi : m_ptr - m_sz;
        end
        exp_addr.push_back(e);
        exp_tag.push_back(tag);
        adv_i = 1; mode_i = 2'(mode);
        @(negedge clk); adv_i = 0;
    endtask

    task automatic drain(string tag);
        repeat (2) @(negedge clk);
        chk(exp_addr.size() == 0, tag, exp_addr.size(), 0);
    endtask

    task automatic window(int lo, int hi, int p);
        wr_lo(lo); wr_hi(hi); wr_pt(p);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state visible at the ports
        chk(addr_vld_o == 0, "R9 vld in reset", int'(addr_vld_o), 0);
        chk(addr_o == 0, "R9 addr in reset", int'(addr_o), 0);
        rst_n = 1;
        @(negedge clk);
        chk(addr_vld_o == 0, "R9 vld after reset", int'(addr_vld_o), 0);
        // R9 and R2: window 0..0, 1-byte step keeps folding to 0
        adv(0, "R9 reset window"); adv(0, "R9 reset window");
        drain("R1 drained");

        // R2, R6: 4-byte upward walk with fold
        wr_cfg(2, 3); window('h100, 'h10C, 'h104);
        for (int i = 0; i < 6; i++) adv(0, "R2 up fold");
        // R3: downward walk with fold to the upper bound
        for (int i = 0; i < 5; i++) adv(1, "R3 down fold");
        drain("R1 drained");

        // R6: 1-byte and 8-byte sizes
        wr_cfg(0, 3); window('h100, 'h103, 'h102);
        for (int i = 0; i < 4; i++) adv(0, "R6 size 1");
        wr_cfg(3, 3); window('h100, 'h110, 'h100);
        for (int i = 0; i < 4; i++) adv(0, "R6 size 8");
        drain("R1 drained");

        // R4: bit-reversed order 3, 2-byte elements, wraps after 8
        wr_cfg(1, 3); window('h200, 'h20E, 'h204);
        for (int i = 0; i < 10; i++) adv(2, "R4 bitrev order3");
        adv(0, "R4 pointer untouched by bitrev");
        adv(3, "R4 index untouched by ring");
        adv(1, "R4 pointer untouched by bitrev");
        adv(2, "R4 index continues");
        drain("R1 drained");

        // R8: pointer write resets the index; upper bound write does not
        adv(2, "R8 before");
        wr_hi('h20E);
        adv(2, "R8 end write keeps index");
        wr_pt('h200);
        adv(2, "R8 ptr write resets index");
        adv(2, "R8 after reset");
        wr_lo('h200);
        adv(2, "R8 start write resets index");
        drain("R1 drained");

        // R5: order clamping
        wr_cfg(0, 0);
        for (int i = 0; i < 3; i++) adv(2, "R5 order 0 acts as 1");
        wr_cfg(0, 15);
        for (int i = 0; i < 4; i++) adv(2, "R5 order 15 acts as 10");
        drain("R1 drained");

        // R2, R3: wraps at the address-space edges
        wr_cfg(2, 3); window('hFFF0, 'hFFFC, 'hFFF8);
        for (int i = 0; i < 4; i++) adv(0, "R2 carry out folds");
        window('h0000, 'h000C, 'h0004);
        for (int i = 0; i < 4; i++) adv(1, "R3 borrow folds");
        drain("R1 drained");

        // R7: write and advance together -> advance dropped
        window('h100, 'h10C, 'h100);
        adv(0, "R7 setup");
        adv(0, "R7 setup");
        drain("R1 drained");
        wr_ptr_i = 1; ptr_i = 16'h108; adv_i = 1; mode_i = 2'b00;
        m_ptr = 'h108;
        @(negedge clk); wr_ptr_i = 0; adv_i = 0;
        chk(addr_vld_o == 0, "R7 collided advance dropped", int'(addr_vld_o), 0);
        adv(0, "R7 new pointer first");
        adv(0, "R7 pointer moved once");
        drain("R1 drained");

        // mixed walks, back to back
        wr_cfg(2, 4); window('h300, 'h33C, 'h320);
        for (int i = 0; i < 40; i++) begin
            int md = (i * 7 + i / 5) % 4;
            adv(md, "R4 mixed walks");
        end
        drain("R1 drained");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog act=%0d exp=%0d", 20000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule